// File: doc/BRIEF.md
# Pixel Raster Operation Unit

This unit merges a source pixel with a destination pixel under an 8-bit raster-operation code. It returns the pixel that a drawing engine writes back to the frame buffer. One pixel goes through per clock. The result is registered, so it appears one cycle after the inputs are sampled. Pixel fetch and address generation belong to the surrounding engine.

Two code tables exist. The plain table applies when the pattern flag is low and combines source with destination. The patterned table applies when the flag is high. In that table the `src_pix` operand carries the pattern colour. One code in the patterned table blends pattern and destination through the third operand, `mask_pix`, which carries the non-pattern source.

The pixel format selects how much of the 16-bit word is computed:
- 8 bpp uses the low byte only.
- 15 bpp protects the destination's top bit.
- 16 bpp uses the full word.

Top module: `rop_pixel_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pix_out` becomes 0.
- R2: `pix_out` changes only at a rising clock edge, and it reflects the inputs sampled at that edge (latency of one cycle).
- R3: With `pat_en`=0, these codes set each result bit as follows: 0x00 gives 0, 0xFF gives 1, 0xCC gives the source, 0x33 gives NOT source, 0xAA gives the destination, and 0x55 gives NOT destination.
- R4: With `pat_en`=0, the two-operand codes give the following results (S is source, D is destination): 0x88 S AND D, 0xEE S OR D, 0x66 S XOR D, 0x99 NOT(S XOR D), 0x11 NOT S AND NOT D, 0x22 D AND NOT S, 0x44 S AND NOT D, 0x77 NOT S OR NOT D, 0xBB D OR NOT S, 0xDD S OR NOT D.
- R5: With `pat_en`=1, the pattern operand P on `src_pix` and the destination D combine as follows:
  - 0x00 gives 0 and 0xFF gives 1.
  - 0xF0 gives P and 0x0F gives NOT P.
  - 0xAA gives D and 0x55 gives NOT D.
  - 0xA0 gives P AND D, 0xFA gives P OR D, 0x5A gives P XOR D, 0xA5 gives NOT(P XOR D).
  - 0x05 gives NOT P AND NOT D, 0x0A gives D AND NOT P, 0x50 gives P AND NOT D, 0x5F gives NOT P OR NOT D.
  - 0xAF gives D OR NOT P and 0xF5 gives P OR NOT D.
- R6: With `pat_en`=1, code 0xB8 gives ((P XOR D) AND M) XOR P, where M is `mask_pix`. Each result bit takes P where M is 0 and D where M is 1.
- R7: A code missing from the active table leaves the destination unchanged. This includes a code that belongs only to the other table (for example 0xF0 with `pat_en`=0, or 0xCC with `pat_en`=1).
- R8: `mode_sel` 2'b10 and 2'b11 select 16 bpp, and all 16 result bits come from the operation.
- R9: `mode_sel` 2'b01 selects 15 bpp. Bits 14:0 come from the operation and bit 15 equals bit 15 of `dst_pix`.
- R10: `mode_sel` 2'b00 selects 8 bpp. Bits 7:0 come from the operation and bits 15:8 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Pixel format: 00 8 bpp, 01 15 bpp, 10/11 16 bpp |
| pat_en | input | 1 | Selects the patterned code table |
| rop_code | input | 8 | Raster-operation code |
| dst_pix | input | 16 | Destination pixel |
| src_pix | input | 16 | Source pixel, or pattern pixel when `pat_en` is 1 |
| mask_pix | input | 16 | Non-pattern source used by the patterned blend code |
| pix_out | output | 16 | New destination pixel, registered |

## Verification
The hardest cases to reach are the codes that must do nothing. These are codes that are valid in the other table, or that are valid in no table at all. A directed list of named codes would never try them.

The stimulus therefore sweeps all 256 codes under both table selections and all four format values. It uses operand triples in which the destination's top bit is set in some triples and clear in others, and in which source and destination disagree bit by bit. Together these reach the 15 bpp top-bit rule and show that no stray decode escapes.

// File: rtl/rop_pkg.sv
// Shared types for the pixel raster operation unit.
// Assumes pixels at most 16 bits wide; the format code is 2 bits.
package rop_pkg;

    // Pixel format select values
    typedef enum logic [1:0] {
        FMT_8BPP  = 2'b00,
        FMT_15BPP = 2'b01,
        FMT_16BPP = 2'b10,
        FMT_16ALT = 2'b11
    } pix_fmt_t;

    // Boolean function chosen by a code; S = source/pattern, D = destination
    typedef enum logic [4:0] {
        FN_ZERO,
        FN_ONES,
        FN_S,
        FN_NS,
        FN_D,
        FN_ND,
        FN_XOR,
        FN_XNOR,
        FN_AND,
        FN_OR,
        FN_NOR,
        FN_D_ANDN_S,
        FN_S_ANDN_D,
        FN_NAND,
        FN_D_ORN_S,
        FN_S_ORN_D,
        FN_BLEND
    } rop_fn_t;

endpackage

// File: rtl/rop_code_decode.sv
// Maps an 8-bit raster code to a boolean function, using one of two tables.
// Assumes: pat_sel chooses the patterned table; any code absent from the
// chosen table maps to FN_D (destination kept).
module rop_code_decode
    import rop_pkg::*;
(
    input  logic [7:0] code,
    input  logic       pat_sel,
    output rop_fn_t    fn
);

    rop_fn_t fn_plain;
    rop_fn_t fn_pat;

    // Plain table: codes are truth tables over source and destination
    always_comb begin
        unique case (code)
            8'h00:   fn_plain = FN_ZERO;
            8'hFF:   fn_plain = FN_ONES;
            8'hCC:   fn_plain = FN_S;
            8'h33:   fn_plain = FN_NS;
            8'h55:   fn_plain = FN_ND;
            8'h66:   fn_plain = FN_XOR;
            8'h99:   fn_plain = FN_XNOR;
            8'h88:   fn_plain = FN_AND;
            8'hEE:   fn_plain = FN_OR;
            8'h11:   fn_plain = FN_NOR;
            8'h22:   fn_plain = FN_D_ANDN_S;
            8'h44:   fn_plain = FN_S_ANDN_D;
            8'h77:   fn_plain = FN_NAND;
            8'hBB:   fn_plain = FN_D_ORN_S;
            8'hDD:   fn_plain = FN_S_ORN_D;
            default: fn_plain = FN_D;
        endcase
    end

    // Patterned table: same functions on pattern and destination, plus a blend
    always_comb begin
        unique case (code)
            8'h00:   fn_pat = FN_ZERO;
            8'hFF:   fn_pat = FN_ONES;
            8'hF0:   fn_pat = FN_S;
            8'h0F:   fn_pat = FN_NS;
            8'h55:   fn_pat = FN_ND;
            8'h5A:   fn_pat = FN_XOR;
            8'hA5:   fn_pat = FN_XNOR;
            8'hA0:   fn_pat = FN_AND;
            8'hFA:   fn_pat = FN_OR;
            8'h05:   fn_pat = FN_NOR;
            8'h0A:   fn_pat = FN_D_ANDN_S;
            8'h50:   fn_pat = FN_S_ANDN_D;
            8'h5F:   fn_pat = FN_NAND;
            8'hAF:   fn_pat = FN_D_ORN_S;
            8'hF5:   fn_pat = FN_S_ORN_D;
            8'hB8:   fn_pat = FN_BLEND;
            default: fn_pat = FN_D;
        endcase
    end

    // Table select
    always_comb fn = pat_sel ? fn_pat : fn_plain;

endmodule

// File: rtl/rop_bool_core.sv
// Applies the decoded boolean function bitwise across the full pixel word.
// Assumes all operands share width W; blend takes s where m=0, d where m=1.
module rop_bool_core
    import rop_pkg::*;
#(
    parameter int W = 16
) (
    input  rop_fn_t        fn,
    input  logic [W-1:0]   d,
    input  logic [W-1:0]   s,
    input  logic [W-1:0]   m,
    output logic [W-1:0]   r
);

    // Bitwise function evaluation
    always_comb begin
        case (fn)
            FN_ZERO:     r = '0;
            FN_ONES:     r = '1;
            FN_S:        r = s;
            FN_NS:       r = ~s;
            FN_D:        r = d;
            FN_ND:       r = ~d;
            FN_XOR:      r = s ^ d;
            FN_XNOR:     r = ~(s ^ d);
            FN_AND:      r = s & d;
            FN_OR:       r = s | d;
            FN_NOR:      r = ~s & ~d;
            FN_D_ANDN_S: r = d & ~s;
            FN_S_ANDN_D: r = s & ~d;
            FN_NAND:     r = ~s | ~d;
            FN_D_ORN_S:  r = d | ~s;
            FN_S_ORN_D:  r = s | ~d;
            FN_BLEND:    r = ((s ^ d) & m) ^ s;
            default:     r = d;
        endcase
    end

endmodule

// File: rtl/rop_width_fit.sv
// Trims the raw result to the selected pixel format.
// Assumes W is even; 8 bpp uses the low W/2 bits, 15 bpp keeps dst's MSB.
module rop_width_fit
    import rop_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]     fmt,
    input  logic [W-1:0]   raw,
    input  logic [W-1:0]   dst,
    output logic [W-1:0]   fit
);

    localparam int HALF_W = W / 2;

    // Format-dependent masking
    always_comb begin
        case (pix_fmt_t'(fmt))
            FMT_8BPP:  fit = {{(W - HALF_W){1'b0}}, raw[HALF_W-1:0]};
            FMT_15BPP: fit = {dst[W-1], raw[W-2:0]};
            default:   fit = raw;
        endcase
    end

endmodule

// File: rtl/rop_pixel_unit.sv
// Pixel raster operation unit: decode code, evaluate, fit to format, register.
// Assumes one pixel per cycle and a synchronous active-low reset.
module rop_pixel_unit
    import rop_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             pat_en,
    input  logic [7:0]       rop_code,
    input  logic [PIX_W-1:0] dst_pix,
    input  logic [PIX_W-1:0] src_pix,
    input  logic [PIX_W-1:0] mask_pix,
    output logic [PIX_W-1:0] pix_out
);

    localparam int HALF_W = PIX_W / 2;

    rop_fn_t          fn_sel;
    logic [PIX_W-1:0] raw_res;
    logic [PIX_W-1:0] fit_res;

    rop_code_decode u_decode (
        .code    (rop_code),
        .pat_sel (pat_en),
        .fn      (fn_sel)
    );

    rop_bool_core #(.W(PIX_W)) u_core (
        .fn (fn_sel),
        .d  (dst_pix),
        .s  (src_pix),
        .m  (mask_pix),
        .r  (raw_res)
    );

    rop_width_fit #(.W(PIX_W)) u_fit (
        .fmt (mode_sel),
        .raw (raw_res),
        .dst (dst_pix),
        .fit (fit_res)
    );

    // Output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= fit_res;
    end

    // R1: the first cycle after reset shows zero
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pix_out == '0);

    // R9: 15 bpp keeps the destination MSB
    assert_msb_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == 2'b01) |-> pix_out[PIX_W-1] == $past(dst_pix[PIX_W-1]));

    // R10: 8 bpp clears the upper half
    assert_upper_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_sel) == 2'b00) |-> pix_out[PIX_W-1:HALF_W] == '0);

    // R6: patterned blend in 16 bpp
    assert_blend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pat_en) && $past(rop_code) == 8'hB8 && $past(mode_sel) == 2'b10)
        |-> pix_out == ((($past(src_pix) ^ $past(dst_pix)) & $past(mask_pix)) ^ $past(src_pix)));

    // R3: plain 0xAA in 16 bpp returns the destination
    assert_keep_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pat_en) && $past(rop_code) == 8'hAA && $past(mode_sel) == 2'b10)
        |-> pix_out == $past(dst_pix));

    // R8: 0xFF in 16 bpp yields all ones in either table
    assert_all_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rop_code) == 8'hFF && $past(mode_sel) == 2'b10)
        |-> pix_out == '1);

endmodule

// File: tb/rop_pixel_unit_tb.sv
// Exhaustive sweep: every code, both tables, all formats, several operands.
// Expected value: the code is read as a truth table indexed by {P,S,D} bits.
module rop_pixel_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic        pat_en = 1'b0;
    logic [7:0]  rop_code = 8'h00;
    logic [15:0] dst_pix = '0;
    logic [15:0] src_pix = '0;
    logic [15:0] mask_pix = '0;
    logic [15:0] pix_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rop_pixel_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .pat_en   (pat_en),
        .rop_code (rop_code),
        .dst_pix  (dst_pix),
        .src_pix  (src_pix),
        .mask_pix (mask_pix),
        .pix_out  (pix_out)
    );

    function automatic bit in_plain(input logic [7:0] c);
        case (c)
            8'h00, 8'hFF, 8'hCC, 8'h33, 8'hAA, 8'h55, 8'h66, 8'h99,
            8'h88, 8'hEE, 8'h11, 8'h22, 8'h44, 8'h77, 8'hBB, 8'hDD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit in_pat(input logic [7:0] c);
        case (c)
            8'h00, 8'hFF, 8'hF0, 8'h0F, 8'hAA, 8'h55, 8'h5A, 8'hA5, 8'hA0,
            8'hFA, 8'h05, 8'h0A, 8'h50, 8'h5F, 8'hAF, 8'hF5, 8'hB8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Reference: plain index {x,S,D} with x=S; patterned index {P,M,D}
    function automatic logic [15:0] model(input logic [1:0] md, input bit pe,
            input logic [7:0] c, input logic [15:0] d, input logic [15:0] s,
            input logic [15:0] m);
        logic [15:0] r;
        bit listed = pe ? in_pat(c) : in_plain(c);
        for (int b = 0; b < 16; b++) begin
            int idx = pe ? (4 * s[b] + 2 * m[b] + d[b]) : (4 * s[b] + 2 * s[b] + d[b]);
            r[b] = listed ? c[idx] : d[b];
        end
        if (md == 2'b00) r = r & 16'h00FF;
        else if (md == 2'b01) r = {d[15], r[14:0]};
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] md, input bit pe, input logic [7:0] c);
        string t;
        if (pe) t = (c == 8'hB8) ? "R6" : (in_pat(c) ? "R5" : "R7");
        else begin
            case (c)
                8'h00, 8'hFF, 8'hCC, 8'h33, 8'hAA, 8'h55: t = "R3";
                default: t = in_plain(c) ? "R4" : "R7";
            endcase
        end
        case (md)
            2'b00:   t = {t, "/R10"};
            2'b01:   t = {t, "/R9"};
            default: t = {t, "/R8"};
        endcase
        return t;
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_vec++;
        if (pix_out !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, pix_out, exp);
        end
    endtask

    logic [15:0] d_set [6] = '{16'h0000, 16'hA5C3, 16'h8001, 16'h1234, 16'hFFFF, 16'h6B2D};
    logic [15:0] s_set [6] = '{16'hFFFF, 16'h3C96, 16'h7FFE, 16'hFEDC, 16'h0000, 16'h94D2};
    logic [15:0] m_set [6] = '{16'h0000, 16'hF00F, 16'h5A5A, 16'h00FF, 16'hAAAA, 16'hC3C3};

    initial begin
        // R1: reset output
        dst_pix = 16'hBEEF; src_pix = 16'h1234; rop_code = 8'hCC; mode_sel = 2'b10;
        repeat (3) @(negedge clk);
        check("R1", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", 16'h1234);
        // R2: new inputs do not reach the output before the next edge
        src_pix = 16'h5555;
        #2;
        check("R2", 16'h1234);
        @(negedge clk);
        check("R2", 16'h5555);

        for (int md = 0; md < 4; md++)
            for (int pe = 0; pe < 2; pe++)
                for (int c = 0; c < 256; c++)
                    for (int k = 0; k < 6; k++) begin
                        mode_sel = md[1:0]; pat_en = pe[0]; rop_code = c[7:0];
                        dst_pix = d_set[k]; src_pix = s_set[k]; mask_pix = m_set[k];
                        @(negedge clk);
                        check(tag_of(md[1:0], pe[0], c[7:0]),
                              model(md[1:0], pe[0], c[7:0], d_set[k], s_set[k], m_set[k]));
                    end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule